// File: doc/BRIEF.md
# Multiplexed-Address SRAM Access Sequencer

This block connects a single-access host interface to an external byte-wide SRAM whose 17-bit address comes partly from a narrow 8-bit address port. The address the memory sees is made of three pieces. The most significant piece is a bank bit driven by a register inside the sequencer. The middle piece is an 8-bit page held in an external latch, which captures the shared port while the latch strobe is high. The least significant piece is the byte currently on the port. The page lives in the latch, so the port is free to carry the low byte. Accesses that stay inside one page therefore only change the port, and no latch cycle is needed.

The host presents `req` with `we`, a 17-bit `addr` and `wdata`. Only one access is in flight at a time, and `done` pulses for one cycle when it completes. The sequencer keeps its own copy of the page it last latched, plus a valid flag. It issues a latch cycle only when that copy is invalid, which is the case after reset, or when it differs from the requested page.

Output enable is held low at rest, so the idle bus is reading. A write first raises output enable. The data bus is then driven for one cycle before write enable falls, and it stays driven for one cycle after write enable rises.

The state machine has eight states:
- IDLE: rest, reading.
- LATCH: page strobe.
- RD: read cycle.
- OEOFF: output enable high.
- SETUP: data driven.
- WPULSE: write enable low.
- WHOLD: data held.
- FINISH: done.

Its transitions are:
- IDLE to LATCH on a request that misses the page.
- IDLE to RD, or IDLE to OEOFF, on a request that hits the page, chosen by `we`.
- LATCH to RD or to OEOFF, chosen by `we`.
- RD to FINISH.
- OEOFF to SETUP, SETUP to WPULSE, WPULSE to WHOLD, and WHOLD to FINISH.
- FINISH to IDLE.

Top module: `sram_mux_seq`

## Requirements
- R1: During and after reset, with no request, the outputs are `page_le`=0, `we_n`=1, `oe_n`=0, `dq_oe`=0, `done`=0, `bank`=0 and `mem_port`=0.
- R2: A read returns the SRAM byte at the full address {bank bit `addr[16]`, page `addr[15:8]`, low byte `addr[7:0]`}. Both banks are distinct 64 KB spaces.
- R3: The access begins with exactly one cycle of `page_le`=1 with `mem_port`=`addr[15:8]` whenever no page has been latched since reset or the requested page differs from the last latched one. In that cycle `we_n`=1 and `dq_oe`=0.
- R4: An access to the last latched page has no latch cycle, whatever its bank. Its first cycle after acceptance is already the read or write sequence.
- R5: A read, counted from the accepting edge, is one RD cycle followed by one FINISH cycle. `oe_n` stays 0 throughout, and `rdata` is captured at the end of RD.
- R6: A write, counted from the accepting edge, runs in this order:
  - OEOFF: `oe_n`=1 with the bus released.
  - SETUP: `dq_oe`=1 with `dq_out`=`wdata`.
  - WPULSE: `we_n`=0 for exactly one cycle.
  - WHOLD: `we_n`=1 with the data still driven.
  - FINISH: `oe_n`=0 with the bus released.
- R7: `dq_oe` is never 1 while `oe_n` is 0.
- R8: `bank` takes `addr[16]` at the accepting edge and changes at no other time.
- R9: `done` is high for exactly one cycle per access, in its FINISH cycle. `rdata` keeps the last read value across writes.
- R10: Outside the latch cycle, `mem_port` shows the low byte of the current or most recent access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Access request, sampled in IDLE |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Byte address: bank, page, low byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Last read data |
| done | output | 1 | One-cycle completion pulse |
| mem_port | output | 8 | Shared address port: low byte, or page during latch |
| page_le | output | 1 | Page latch strobe, active high |
| bank | output | 1 | Bank address bit |
| we_n | output | 1 | SRAM write enable, active low |
| oe_n | output | 1 | SRAM output enable, active low |
| dq_out | output | 8 | Data driven toward the SRAM |
| dq_oe | output | 1 | Data bus drive enable |
| dq_in | input | 8 | Data returned by the SRAM |

## Verification
The bench builds the block with its default widths: an 8-bit low byte, an 8-bit page and 8-bit data. This gives a 17-bit address with a 256-entry page space. These values make the page-0 request right after reset reachable. That request must still latch, because the valid flag is clear. They also make the page 0xFF and address 0x0FFFF boundaries reachable, as well as a bank flip that reuses the same latched page without a latch cycle. A behavioural SRAM and page latch in the bench, driven only by the pins, show whether bank, page and low byte really combine into distinct addresses.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_LATCH,
        S_RD,
        S_OEOFF,
        S_SETUP,
        S_WPULSE,
        S_WHOLD,
        S_FINISH
    } seq_state_t;
endpackage

// File: rtl/sram_page_track.sv
module sram_page_track #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAGE_W-1:0] load_page,
    input  logic [PAGE_W-1:0] probe_page,
    output logic              hit
);
    logic              valid_q;
    logic [PAGE_W-1:0] page_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            page_q  <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            page_q  <= load_page;
        end
    end

    assign hit = valid_q && (page_q == probe_page);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_seq_pkg::*;
#(
    parameter int LO_W   = 8,
    parameter int PAGE_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req,
    input  logic                   we,
    input  logic [PAGE_W+LO_W:0]   addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic                   page_hit,
    input  logic [DATA_W-1:0]      dq_in,
    output logic                   latch_load,
    output logic [PAGE_W-1:0]      latch_page,
    output logic [LO_W-1:0]        port,
    output logic                   page_le,
    output logic                   bank,
    output logic                   we_n,
    output logic                   oe_n,
    output logic [DATA_W-1:0]      dq_out,
    output logic                   dq_oe,
    output logic [DATA_W-1:0]      rdata,
    output logic                   done
);
    localparam int BANK_BIT = PAGE_W + LO_W;

    seq_state_t        state, nxt;
    logic [LO_W-1:0]   lo_q;
    logic [PAGE_W-1:0] hi_q;
    logic              bank_q;
    logic              we_q;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] rd_q;

    wire accept = (state == S_IDLE) && req;

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            lo_q   <= '0;
            hi_q   <= '0;
            bank_q <= 1'b0;
            we_q   <= 1'b0;
            wd_q   <= '0;
            rd_q   <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                lo_q   <= addr[LO_W-1:0];
                hi_q   <= addr[LO_W +: PAGE_W];
                bank_q <= addr[BANK_BIT];
                we_q   <= we;
                wd_q   <= wdata;
            end
            if (state == S_RD) begin
                rd_q <= dq_in;
            end
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (req) begin
                    if (!page_hit) nxt = S_LATCH;
                    else if (we)   nxt = S_OEOFF;
                    else           nxt = S_RD;
                end
            end
            S_LATCH:  nxt = we_q ? S_OEOFF : S_RD;
            S_RD:     nxt = S_FINISH;
            S_OEOFF:  nxt = S_SETUP;
            S_SETUP:  nxt = S_WPULSE;
            S_WPULSE: nxt = S_WHOLD;
            S_WHOLD:  nxt = S_FINISH;
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        page_le    = 1'b0;
        latch_load = 1'b0;
        we_n       = 1'b1;
        oe_n       = 1'b0;
        dq_oe      = 1'b0;
        done       = 1'b0;
        port       = lo_q;
        unique case (state)
            S_LATCH: begin
                page_le    = 1'b1;
                latch_load = 1'b1;
                port       = hi_q;
            end
            S_OEOFF: oe_n = 1'b1;
            S_SETUP, S_WHOLD: begin
                oe_n  = 1'b1;
                dq_oe = 1'b1;
            end
            S_WPULSE: begin
                oe_n  = 1'b1;
                dq_oe = 1'b1;
                we_n  = 1'b0;
            end
            S_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    assign latch_page = hi_q;
    assign bank       = bank_q;
    assign dq_out     = wd_q;
    assign rdata      = rd_q;
endmodule

// File: rtl/sram_mux_seq.sv
module sram_mux_seq #(
    parameter int LO_W   = 8,
    parameter int PAGE_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 we,
    input  logic [PAGE_W+LO_W:0] addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 done,
    output logic [LO_W-1:0]      mem_port,
    output logic                 page_le,
    output logic                 bank,
    output logic                 we_n,
    output logic                 oe_n,
    output logic [DATA_W-1:0]    dq_out,
    output logic                 dq_oe,
    input  logic [DATA_W-1:0]    dq_in
);
    logic              page_hit;
    logic              latch_load;
    logic [PAGE_W-1:0] latch_page;

    sram_page_track #(.PAGE_W(PAGE_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (latch_load),
        .load_page  (latch_page),
        .probe_page (addr[LO_W +: PAGE_W]),
        .hit        (page_hit)
    );

    sram_seq_fsm #(.LO_W(LO_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .we         (we),
        .addr       (addr),
        .wdata      (wdata),
        .page_hit   (page_hit),
        .dq_in      (dq_in),
        .latch_load (latch_load),
        .latch_page (latch_page),
        .port       (mem_port),
        .page_le    (page_le),
        .bank       (bank),
        .we_n       (we_n),
        .oe_n       (oe_n),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe),
        .rdata      (rdata),
        .done       (done)
    );
endmodule

// File: rtl/sram_mux_seq_chk.sv
module sram_mux_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic done,
    input logic page_le,
    input logic bank,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe
);
    p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dq_oe && !oe_n));

    p_we_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (dq_oe && $past(dq_oe)));

    p_we_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> dq_oe);

    p_we_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> we_n);

    p_latch_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        page_le |-> (we_n && !dq_oe));

    p_latch_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        page_le |=> !page_le);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_bank_on_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank) |-> $past(req));
endmodule

bind sram_mux_seq sram_mux_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .done    (done),
    .page_le (page_le),
    .bank    (bank),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .dq_oe   (dq_oe)
);

// File: tb/sram_mux_seq_bench.sv
`timescale 1ns/1ps
module sram_mux_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        done;
    logic [7:0]  mem_port;
    logic        page_le;
    logic        bank;
    logic        we_n;
    logic        oe_n;
    logic [7:0]  dq_out;
    logic        dq_oe;
    logic [7:0]  dq_in = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    sram_mux_seq u_sram_mux_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .done(done), .mem_port(mem_port),
        .page_le(page_le), .bank(bank), .we_n(we_n), .oe_n(oe_n),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    // behavioural SRAM with its external page latch
    logic [7:0] smem [int];
    logic [7:0] sram_latch = '0;
    int         mem_gen = 0;

    function automatic logic [7:0] init_byte(int a);
        logic [7:0] v;
        v = a[7:0] * 8'd3;
        v = v ^ a[15:8];
        if (a[16]) v = v ^ 8'h5A;
        return v;
    endfunction

    function automatic logic [7:0] sram_read(int a);
        if (smem.exists(a)) return smem[a];
        return init_byte(a);
    endfunction

    always @(posedge clk) begin
        if (!we_n) begin
            smem[int'({bank, sram_latch, mem_port})] = dq_out;
            mem_gen = mem_gen + 1;
        end
        if (page_le) sram_latch <= mem_port;
    end

    always @(bank or sram_latch or mem_port or oe_n or mem_gen)
        dq_in = oe_n ? 8'h00 : sram_read(int'({bank, sram_latch, mem_port}));

    // golden memory from the host's point of view
    logic [7:0] gold [int];

    // reference model: expected pin values per cycle
    typedef struct {
        bit       le;
        bit       wen;
        bit       oen;
        bit       doe;
        bit       dn;
        int       port;
        bit       is_rd;
        int       data;
        int       wd;
        string    le_tag;
    } exp_t;

    exp_t exp_q[$];
    bit   bvalid = 1'b0;
    int   bpage = 0;
    int   last_lo = 0;
    int   last_rd = 0;
    bit   exp_bank = 1'b0;
    bit   run_cmp = 1'b0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            exp_t e;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
            end else begin
                e.le = 0; e.wen = 1; e.oen = 0; e.doe = 0; e.dn = 0;
                e.port = last_lo; e.is_rd = 0; e.data = 0; e.wd = 0;
                e.le_tag = "R1";
            end
            chk(e.le_tag, int'(page_le), int'(e.le));
            chk("R10", int'(mem_port), e.port);
            chk("R6", int'(we_n), int'(e.wen));
            chk("R5", int'(oe_n), int'(e.oen));
            chk("R7", int'(dq_oe), int'(e.doe));
            chk("R9", int'(done), int'(e.dn));
            chk("R8", int'(bank), int'(exp_bank));
            if (e.doe) chk("R6", int'(dq_out), e.wd);
            if (e.dn && e.is_rd) begin
                chk("R2", int'(rdata), e.data);
                last_rd = e.data;
            end else if (e.dn) begin
                chk("R9", int'(rdata), last_rd);
            end
        end
    end

    function automatic exp_t mk(bit le, bit wen, bit oen, bit doe, bit dn,
                                int port, string tag);
        exp_t e;
        e.le = le; e.wen = wen; e.oen = oen; e.doe = doe; e.dn = dn;
        e.port = port; e.is_rd = 0; e.data = 0; e.wd = 0; e.le_tag = tag;
        return e;
    endfunction

    task automatic access(bit w, int a, int d);
        bit    need;
        int    lo;
        string tg;
        exp_t  e;
        lo   = a & 8'hFF;
        need = !bvalid || (bpage != ((a >> 8) & 8'hFF));
        tg   = need ? "R3" : "R4";
        req = 1'b1; we = w; addr = a[16:0]; wdata = d[7:0];
        exp_bank = a[16];
        if (need) begin
            exp_q.push_back(mk(1, 1, 0, 0, 0, (a >> 8) & 8'hFF, "R3"));
            bvalid = 1'b1;
            bpage  = (a >> 8) & 8'hFF;
        end
        if (!w) begin
            exp_q.push_back(mk(0, 1, 0, 0, 0, lo, tg));
            e = mk(0, 1, 0, 0, 1, lo, tg);
            e.is_rd = 1;
            e.data  = gold.exists(a) ? int'(gold[a]) : int'(init_byte(a));
            exp_q.push_back(e);
        end else begin
            exp_q.push_back(mk(0, 1, 1, 0, 0, lo, tg));
            e = mk(0, 1, 1, 1, 0, lo, tg); e.wd = d & 8'hFF; exp_q.push_back(e);
            e = mk(0, 0, 1, 1, 0, lo, tg); e.wd = d & 8'hFF; exp_q.push_back(e);
            e = mk(0, 1, 1, 1, 0, lo, tg); e.wd = d & 8'hFF; exp_q.push_back(e);
            exp_q.push_back(mk(0, 1, 0, 0, 1, lo, tg));
            gold[a] = d[7:0];
        end
        last_lo = lo;
        @(posedge clk);
        #1 req = 1'b0;
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() == 0) break;
        end
        @(negedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", int'(page_le), 0);
        chk("R1", int'(we_n), 1);
        chk("R1", int'(oe_n), 0);
        chk("R1", int'(dq_oe), 0);
        chk("R1", int'(done), 0);
        chk("R1", int'(bank), 0);
        chk("R1", int'(mem_port), 0);
        #1 rst_n = 1'b1;
        run_cmp = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        access(0, 17'h00010, 0);      // page 0 still latches after reset (R3)
        access(0, 17'h00011, 0);      // same page (R4)
        access(1, 17'h00012, 8'hA5);  // write same page (R6)
        access(0, 17'h00012, 0);      // read back (R2)
        access(0, 17'h10012, 0);      // other bank, same page, no latch (R8, R4)
        access(1, 17'h13400, 8'h3C);  // new page write (R3)
        access(0, 17'h03400, 0);      // bank 0 untouched (R2)
        access(0, 17'h13400, 0);      // bank 1 value (R2)
        access(0, 17'h0FF01, 0);      // page 0xFF
        access(1, 17'h0FFFF, 8'h77);
        access(1, 17'h1FFFF, 8'h88);
        access(0, 17'h0FFFF, 0);
        access(0, 17'h1FFFF, 0);
        for (int i = 0; i < 8; i++) access(0, 17'h05520 + i, 0);
        for (int i = 0; i < 4; i++) access(1, 17'h05520 + i, 8'h10 + i);
        for (int i = 0; i < 4; i++) access(0, 17'h05520 + i, 0);
        access(0, 17'h00011, 0);      // back to page 0, relatch (R3)
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule